// File: doc/BRIEF.md
# Coefficient Memory Loading Controller

This block is the load-side front end of a multirate FIR filter. It holds a small configuration word and turns a shared loading bus into write cycles for the filter's coefficient store. The store has six banks of 108 words of 24 bits each. Every bank serves two adjacent 12-bit taps, so one bank word carries two tap coefficients and one location index across all six banks forms a complete filter set. The controller drives the write side of those banks with a one-hot bank enable, a location, replicated write data and a per-bit write mask. The storage itself, the multiply-accumulate datapath and the run mode lie outside this block.

A configure strobe puts the control logic into reset while it is high, and its falling edge captures the low seven bits of the data bus as the configuration word. This reset leaves the coefficient banks untouched, so a loaded filter can be reconfigured without reloading. Three loading modes are available. Parallel mode writes one byte on every clock that the strobe is high. Microprocessor mode writes one byte for each rising edge of the strobe. Serial mode shifts the whole store in one bit at a time and then raises a completion flag. An active-low select lets several devices share one loading bus.

Top module: `coef_load_ctrl`

## Requirements
- R1: While rst_ni is low, all outputs are zero, including cfg_o and load_done_o.
- R2: While cfg_i is high, and on the clock where it falls, no write is issued. A high cfg_i clears the byte pointer, the serial position and load_done_o. cfg_o keeps its value while cfg_i is high.
- R3: On the clock where cfg_i is sampled low after being sampled high, cfg_o takes data_i[6:0]. data_i[7] is dropped.
- R4: cfg_o[1:0] selects the mode: 00 parallel, 01 microprocessor, 10 serial. Code 11 issues no writes.
- R5: In parallel mode, each clock with wr_i high and sel_ni low produces one write, visible on the outputs after the next rising clock edge. The write uses bank addr_i[9:7] (one-hot on bank_we_o) and location addr_i[6:0]. The byte is replicated to all three lanes of bank_wdata_o, and bank_bmask_o is 8'hFF shifted left by 8 times the current lane. When no write is issued, every write output is zero.
- R6: The byte lane starts at 0 and advances by one for each accepted parallel or microprocessor write, returning to 0 after lane 2 (lane 0 is the least significant byte). Eighteen writes therefore fill one filter set across the six banks.
- R7: A write whose bank field is 6 or 7, or whose location is 108 or above, is dropped and does not advance the byte lane.
- R8: In microprocessor mode, a write is issued only on a rising edge of wr_i (wr_i high after a sampled low), no matter how long the strobe stays high.
- R9: With sel_ni high, no mode issues a write, and neither the byte lane nor the serial position advances.
- R10: In serial mode, each falling edge of wr_i (wr_i low after a sampled high) writes data_i[7] to a single bit. bank_bmask_o is one-hot and the bit is replicated across bank_wdata_o. Positions run from bit 0 to bit 23, then location 0 to 107, then bank 0 to 5.
- R11: load_done_o rises together with the write of bank 5, location 107, bit 23. It stays high until cfg_i goes high, and further serial strobes issue no write.
- R12: At most one bank write enable is active in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_i | input | 1 | Configure strobe: high holds the control logic in reset, falling edge captures the configuration |
| data_i | input | 8 | Loading data bus; bit 7 is the serial input |
| addr_i | input | 10 | Bank field [9:7] and location [6:0] |
| wr_i | input | 1 | Write strobe |
| sel_ni | input | 1 | Device select, active low |
| cfg_o | output | 7 | Configuration word |
| bank_we_o | output | 6 | One-hot bank write enable |
| bank_addr_o | output | 7 | Location within the bank |
| bank_wdata_o | output | 24 | Write data |
| bank_bmask_o | output | 24 | Per-bit write mask |
| load_done_o | output | 1 | Serial load complete |

## Verification
The hardest state to reach from the ports is the end of a serial load. Completion only happens after 15,552 single-bit strobes, and the rollovers from bit to location and from location to bank sit deep inside that run. The stimulus therefore drives the entire serial fill. For every strobe it predicts the bank, location and bit from a running index and checks that the completion flag stays low until the last write. It then confirms that later strobes are ignored, and that reconfiguring clears the flag and restarts the fill at bit 0.

// File: rtl/coef_load_pkg.sv
package coef_load_pkg;
  localparam int unsigned NUM_BANKS_D = 6;
  localparam int unsigned DEPTH_D     = 108;
  localparam int unsigned WORD_W_D    = 24;
  localparam int unsigned BYTE_W      = 8;
  localparam int unsigned ADDR_W_D    = 10;
  localparam int unsigned CFG_W_D     = 7;

  typedef enum logic [1:0] {
    MODE_PAR = 2'b00,
    MODE_UP  = 2'b01,
    MODE_SER = 2'b10,
    MODE_OFF = 2'b11
  } load_mode_e;
endpackage

// File: rtl/clc_cfg_ctrl.sv
module clc_cfg_ctrl #(
  parameter int unsigned CFG_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_i,
  input  logic [CFG_W-1:0] data_i,
  output logic [CFG_W-1:0] cfg_o,
  output logic             clr_o,
  output logic             hold_o
);
  logic cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= 1'b0;
      cfg_o <= '0;
    end else begin
      cfg_q <= cfg_i;
      if (cfg_q && !cfg_i) cfg_o <= data_i;
    end
  end

  assign clr_o  = cfg_i;
  // the falling-edge clock still carries the configuration on the bus
  assign hold_o = cfg_i | cfg_q;
endmodule

// File: rtl/clc_strobe.sv
module clc_strobe
  import coef_load_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  load_mode_e mode_i,
  input  logic       wr_i,
  input  logic       sel_ni,
  input  logic       hold_i,
  output logic       par_stb_o,
  output logic       ser_stb_o
);
  logic wr_q, rise, fall, ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wr_q <= 1'b0;
    else         wr_q <= wr_i;
  end

  always_comb begin
    rise = wr_i & ~wr_q;
    fall = ~wr_i & wr_q;
    ok   = ~sel_ni & ~hold_i;
    par_stb_o = ok & (((mode_i == MODE_PAR) & wr_i) | ((mode_i == MODE_UP) & rise));
    ser_stb_o = ok & (mode_i == MODE_SER) & fall;
  end
endmodule

// File: rtl/clc_par_addr.sv
module clc_par_addr #(
  parameter int unsigned NUM_BANKS = 6,
  parameter int unsigned DEPTH     = 108,
  parameter int unsigned ADDR_W    = 10,
  parameter int unsigned BYTES     = 3
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       clr_i,
  input  logic                       stb_i,
  input  logic [ADDR_W-1:0]          addr_i,
  output logic                       wr_o,
  output logic [NUM_BANKS-1:0]       bank_oh_o,
  output logic [$clog2(DEPTH)-1:0]   loc_o,
  output logic [BYTES-1:0]           lane_oh_o
);
  localparam int unsigned LOC_W  = $clog2(DEPTH);
  localparam int unsigned BF_W   = ADDR_W - LOC_W;
  localparam int unsigned LANE_W = (BYTES > 1) ? $clog2(BYTES) : 1;
  localparam logic [BF_W-1:0]   LAST_BANK = BF_W'(NUM_BANKS - 1);
  localparam logic [LOC_W-1:0]  LAST_LOC  = LOC_W'(DEPTH - 1);
  localparam logic [LANE_W-1:0] LAST_LANE = LANE_W'(BYTES - 1);

  logic [BF_W-1:0]   bank_f;
  logic [LANE_W-1:0] lane_q;
  logic              in_range;

  assign bank_f   = addr_i[ADDR_W-1:LOC_W];
  assign loc_o    = addr_i[LOC_W-1:0];
  assign in_range = (bank_f <= LAST_BANK) && (loc_o <= LAST_LOC);
  assign wr_o     = stb_i & in_range;

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    assign bank_oh_o[g] = (bank_f == BF_W'(g));
  end
  for (genvar g = 0; g < BYTES; g++) begin : g_lane
    assign lane_oh_o[g] = (lane_q == LANE_W'(g));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      lane_q <= '0;
    else if (clr_i)   lane_q <= '0;
    else if (wr_o)    lane_q <= (lane_q == LAST_LANE) ? '0 : lane_q + 1'b1;
  end
endmodule

// File: rtl/clc_ser_seq.sv
module clc_ser_seq #(
  parameter int unsigned NUM_BANKS = 6,
  parameter int unsigned DEPTH     = 108,
  parameter int unsigned WORD_W    = 24
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     clr_i,
  input  logic                     stb_i,
  output logic                     wr_o,
  output logic [NUM_BANKS-1:0]     bank_oh_o,
  output logic [$clog2(DEPTH)-1:0] loc_o,
  output logic [WORD_W-1:0]        bit_oh_o,
  output logic                     done_o
);
  localparam int unsigned BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
  localparam int unsigned LOC_W  = $clog2(DEPTH);
  localparam int unsigned BIT_W  = $clog2(WORD_W);
  localparam logic [BANK_W-1:0] LAST_BANK = BANK_W'(NUM_BANKS - 1);
  localparam logic [LOC_W-1:0]  LAST_LOC  = LOC_W'(DEPTH - 1);
  localparam logic [BIT_W-1:0]  LAST_BIT  = BIT_W'(WORD_W - 1);

  logic [BANK_W-1:0] bank_q;
  logic [LOC_W-1:0]  loc_q;
  logic [BIT_W-1:0]  bit_q;
  logic              done_q;

  assign wr_o   = stb_i & ~done_q;
  assign loc_o  = loc_q;
  assign done_o = done_q;

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    assign bank_oh_o[g] = (bank_q == BANK_W'(g));
  end
  for (genvar g = 0; g < WORD_W; g++) begin : g_bit
    assign bit_oh_o[g] = (bit_q == BIT_W'(g));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bank_q <= '0;
      loc_q  <= '0;
      bit_q  <= '0;
      done_q <= 1'b0;
    end else if (clr_i) begin
      bank_q <= '0;
      loc_q  <= '0;
      bit_q  <= '0;
      done_q <= 1'b0;
    end else if (wr_o) begin
      if (bit_q != LAST_BIT) begin
        bit_q <= bit_q + 1'b1;
      end else begin
        bit_q <= '0;
        if (loc_q != LAST_LOC) begin
          loc_q <= loc_q + 1'b1;
        end else begin
          loc_q <= '0;
          if (bank_q != LAST_BANK) bank_q <= bank_q + 1'b1;
          else                     done_q <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/coef_load_ctrl.sv
module coef_load_ctrl
  import coef_load_pkg::*;
#(
  parameter int unsigned NUM_BANKS = NUM_BANKS_D,
  parameter int unsigned DEPTH     = DEPTH_D,
  parameter int unsigned WORD_W    = WORD_W_D,
  parameter int unsigned ADDR_W    = ADDR_W_D,
  parameter int unsigned CFG_W     = CFG_W_D,
  localparam int unsigned LOC_W    = $clog2(DEPTH)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cfg_i,
  input  logic [BYTE_W-1:0]    data_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic                 wr_i,
  input  logic                 sel_ni,
  output logic [CFG_W-1:0]     cfg_o,
  output logic [NUM_BANKS-1:0] bank_we_o,
  output logic [LOC_W-1:0]     bank_addr_o,
  output logic [WORD_W-1:0]    bank_wdata_o,
  output logic [WORD_W-1:0]    bank_bmask_o,
  output logic                 load_done_o
);
  localparam int unsigned BYTES = WORD_W / BYTE_W;

  logic                 clr, hold, par_stb, ser_stb;
  load_mode_e           mode;
  logic                 par_wr, ser_wr;
  logic [NUM_BANKS-1:0] par_bank, ser_bank;
  logic [LOC_W-1:0]     par_loc, ser_loc;
  logic [BYTES-1:0]     lane_oh;
  logic [WORD_W-1:0]    par_mask, ser_mask;
  logic                 ser_done;

  logic [NUM_BANKS-1:0] we_d;
  logic [LOC_W-1:0]     addr_d;
  logic [WORD_W-1:0]    wdata_d, mask_d;

  clc_cfg_ctrl #(.CFG_W(CFG_W)) u_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cfg_i  (cfg_i),
    .data_i (data_i[CFG_W-1:0]),
    .cfg_o  (cfg_o),
    .clr_o  (clr),
    .hold_o (hold)
  );

  assign mode = load_mode_e'(cfg_o[1:0]);

  clc_strobe u_stb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mode_i    (mode),
    .wr_i      (wr_i),
    .sel_ni    (sel_ni),
    .hold_i    (hold),
    .par_stb_o (par_stb),
    .ser_stb_o (ser_stb)
  );

  clc_par_addr #(
    .NUM_BANKS (NUM_BANKS),
    .DEPTH     (DEPTH),
    .ADDR_W    (ADDR_W),
    .BYTES     (BYTES)
  ) u_par (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (clr),
    .stb_i     (par_stb),
    .addr_i    (addr_i),
    .wr_o      (par_wr),
    .bank_oh_o (par_bank),
    .loc_o     (par_loc),
    .lane_oh_o (lane_oh)
  );

  clc_ser_seq #(
    .NUM_BANKS (NUM_BANKS),
    .DEPTH     (DEPTH),
    .WORD_W    (WORD_W)
  ) u_ser (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (clr),
    .stb_i     (ser_stb),
    .wr_o      (ser_wr),
    .bank_oh_o (ser_bank),
    .loc_o     (ser_loc),
    .bit_oh_o  (ser_mask),
    .done_o    (ser_done)
  );

  for (genvar g = 0; g < BYTES; g++) begin : g_lane_mask
    assign par_mask[g*BYTE_W +: BYTE_W] = {BYTE_W{lane_oh[g]}};
  end

  always_comb begin
    we_d    = '0;
    addr_d  = '0;
    wdata_d = '0;
    mask_d  = '0;
    if (par_wr) begin
      we_d    = par_bank;
      addr_d  = par_loc;
      wdata_d = {BYTES{data_i}};
      mask_d  = par_mask;
    end else if (ser_wr) begin
      we_d    = ser_bank;
      addr_d  = ser_loc;
      wdata_d = {WORD_W{data_i[BYTE_W-1]}};
      mask_d  = ser_mask;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bank_we_o    <= '0;
      bank_addr_o  <= '0;
      bank_wdata_o <= '0;
      bank_bmask_o <= '0;
    end else begin
      bank_we_o    <= we_d;
      bank_addr_o  <= addr_d;
      bank_wdata_o <= wdata_d;
      bank_bmask_o <= mask_d;
    end
  end

  assign load_done_o = ser_done;
endmodule

// File: rtl/coef_load_chk.sv
module coef_load_chk #(
  parameter int unsigned NUM_BANKS = 6,
  parameter int unsigned WORD_W    = 24,
  parameter int unsigned CFG_W     = 7
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 cfg_i,
  input logic                 sel_ni,
  input logic [NUM_BANKS-1:0] bank_we_o,
  input logic [WORD_W-1:0]    bank_bmask_o,
  input logic [CFG_W-1:0]     cfg_o,
  input logic                 load_done_o
);
  a_r12_one_bank: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(bank_we_o));

  a_r2_cfg_blocks_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_i |=> (bank_we_o == '0));

  a_r2_cfg_clears_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_i |=> !load_done_o);

  a_r9_sel_blocks_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_ni |=> (bank_we_o == '0));

  a_r11_done_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_done_o && !cfg_i) |=> load_done_o);

  a_r3_cfg_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cfg_o) |-> (!$past(cfg_i) && $past(cfg_i, 2)));

  a_r5_mask_shape: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bank_we_o != '0) |-> ($countones(bank_bmask_o) == 8 || $countones(bank_bmask_o) == 1));

  a_r5_idle_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bank_we_o == '0) |-> (bank_bmask_o == '0));
endmodule

bind coef_load_ctrl coef_load_chk #(
  .NUM_BANKS (NUM_BANKS),
  .WORD_W    (WORD_W),
  .CFG_W     (CFG_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cfg_i        (cfg_i),
  .sel_ni       (sel_ni),
  .bank_we_o    (bank_we_o),
  .bank_bmask_o (bank_bmask_o),
  .cfg_o        (cfg_o),
  .load_done_o  (load_done_o)
);

// File: tb/coef_load_ctrl_test.sv
module coef_load_ctrl_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_i = 1'b0;
  logic [7:0]  data_i = '0;
  logic [9:0]  addr_i = '0;
  logic        wr_i = 1'b0;
  logic        sel_ni = 1'b0;
  logic [6:0]  cfg_o;
  logic [5:0]  bank_we_o;
  logic [6:0]  bank_addr_o;
  logic [23:0] bank_wdata_o;
  logic [23:0] bank_bmask_o;
  logic        load_done_o;

  int tests = 0;
  int fails = 0;
  int cycles = 0;

  coef_load_ctrl uut (
    .clk_i, .rst_ni, .cfg_i, .data_i, .addr_i, .wr_i, .sel_ni,
    .cfg_o, .bank_we_o, .bank_addr_o, .bank_wdata_o, .bank_bmask_o, .load_done_o
  );

  always #4 clk_i = ~clk_i;

  // {sel_n, bank[2:0], loc[6:0], data[7:0], exp_we[5:0], exp_lane[1:0]} lane 3 = no write
  localparam logic [26:0] VEC [0:7] = '{
    {1'b0, 3'd0, 7'd5,   8'h11, 6'h01, 2'd0},
    {1'b0, 3'd0, 7'd5,   8'h22, 6'h01, 2'd1},
    {1'b0, 3'd6, 7'd5,   8'h99, 6'h00, 2'd3},
    {1'b0, 3'd0, 7'd110, 8'h98, 6'h00, 2'd3},
    {1'b1, 3'd1, 7'd3,   8'h97, 6'h00, 2'd3},
    {1'b0, 3'd0, 7'd5,   8'h33, 6'h01, 2'd2},
    {1'b0, 3'd5, 7'd107, 8'h44, 6'h20, 2'd0},
    {1'b0, 3'd2, 7'd0,   8'h55, 6'h04, 2'd1}
  };

  task automatic tick();
    @(posedge clk_i);
    #1;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic configure(input logic [7:0] val);
    wr_i = 1'b0;
    cfg_i = 1'b1;
    data_i = val;
    tick();
    tick();
    cfg_i = 1'b0;
    tick();
  endtask

  initial begin
    forever begin
      @(posedge clk_i);
      cycles++;
      if (cycles > 150000) begin
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    end
  end

  initial begin
    int errs;
    int early;
    tick(); tick();
    // R1 reset state
    chk("R1 we", 32'(bank_we_o), 0);
    chk("R1 cfg", 32'(cfg_o), 0);
    chk("R1 mask/done", {7'(0), bank_bmask_o, load_done_o}, 0);
    rst_ni = 1'b1;
    tick();

    // R3 configuration capture, bit 7 dropped
    configure(8'hC6);
    chk("R3 cfg capture", 32'(cfg_o), 32'h46);

    // R2 writes blocked and cfg_o held while configuring
    configure(8'h00);
    addr_i = {3'd1, 7'd9};
    data_i = 8'h55;
    wr_i = 1'b1;
    cfg_i = 1'b1;
    tick();
    chk("R2 no write cfg high", 32'(bank_we_o), 0);
    chk("R2 cfg held", 32'(cfg_o), 0);
    cfg_i = 1'b0;
    tick();
    chk("R2 no write on fall", 32'(bank_we_o), 0);
    chk("R3 cfg after fall", 32'(cfg_o), 32'h55);
    wr_i = 1'b0;

    // R5 R7 R9 parallel table
    configure(8'h00);
    for (int i = 0; i < 8; i++) begin
      sel_ni = VEC[i][26];
      addr_i = VEC[i][25:16];
      data_i = VEC[i][15:8];
      wr_i = 1'b1;
      tick();
      chk($sformatf("R5 R7 R9 vec%0d we", i), 32'(bank_we_o), 32'(VEC[i][7:2]));
      if (VEC[i][1:0] != 2'd3) begin
        chk($sformatf("R5 R6 vec%0d mask", i), 32'(bank_bmask_o), 32'(24'hFF) << (8 * VEC[i][1:0]));
        chk($sformatf("R5 vec%0d data/addr", i), {1'b0, bank_addr_o, bank_wdata_o},
            {1'b0, VEC[i][22:16], {3{VEC[i][15:8]}}});
      end
    end
    wr_i = 1'b0;
    sel_ni = 1'b0;
    tick();

    // R6 one filter set in 18 writes
    configure(8'h00);
    errs = 0;
    for (int b = 0; b < 6; b++) begin
      for (int k = 0; k < 3; k++) begin
        addr_i = {3'(b), 7'd9};
        data_i = 8'(b * 16 + k);
        wr_i = 1'b1;
        tick();
        if (bank_we_o !== 6'(1 << b) || bank_bmask_o !== (24'hFF << (8 * k)) || bank_addr_o !== 7'd9)
          errs++;
      end
    end
    wr_i = 1'b0;
    chk("R6 full set lanes", 32'(errs), 0);
    tick();

    // R8 microprocessor mode
    configure(8'h01);
    addr_i = {3'd1, 7'd7};
    data_i = 8'hA1;
    wr_i = 1'b1;
    tick();
    chk("R8 rise write", 32'(bank_we_o), 32'h02);
    chk("R8 lane0", 32'(bank_bmask_o), 32'h0000FF);
    tick();
    chk("R8 held strobe", 32'(bank_we_o), 0);
    tick();
    chk("R8 held strobe 2", 32'(bank_we_o), 0);
    wr_i = 1'b0;
    tick();
    data_i = 8'hA2;
    wr_i = 1'b1;
    tick();
    chk("R8 R6 second rise lane1", 32'(bank_bmask_o), 32'h00FF00);
    wr_i = 1'b0;
    tick();

    // R4 code 11 writes nothing
    configure(8'h03);
    errs = 0;
    for (int i = 0; i < 4; i++) begin
      wr_i = ~wr_i;
      tick();
      if (bank_we_o !== 6'h00) errs++;
    end
    wr_i = 1'b0;
    tick();
    chk("R4 mode 11 idle", 32'(errs), 0);

    // R9 serial ignores deselected strobe
    configure(8'h02);
    sel_ni = 1'b1;
    wr_i = 1'b1;
    tick();
    wr_i = 1'b0;
    tick();
    chk("R9 serial deselected", 32'(bank_we_o), 0);
    sel_ni = 1'b0;

    // R10 R11 full serial fill
    errs = 0;
    early = 0;
    for (int i = 0; i < 15552; i++) begin
      logic dbit;
      dbit = 1'(i) ^ 1'(i >> 4);
      data_i = {dbit, 7'h00};
      wr_i = 1'b1;
      tick();
      wr_i = 1'b0;
      tick();
      if (bank_we_o !== 6'(1 << (i / 2592)) || bank_addr_o !== 7'((i / 24) % 108) ||
          bank_bmask_o !== 24'(1 << (i % 24)) || bank_wdata_o !== {24{dbit}}) begin
        if (errs < 3) $display("FAIL R10 bit %0d we %h addr %0d mask %h", i, bank_we_o, bank_addr_o, bank_bmask_o);
        errs++;
      end
      if (i < 15551 && load_done_o) early++;
    end
    tests++;
    if (errs != 0) fails++;
    chk("R11 done not early", 32'(early), 0);
    chk("R11 done at end", 32'(load_done_o), 1);
    wr_i = 1'b1;
    tick();
    wr_i = 1'b0;
    tick();
    chk("R11 strobe after done", 32'(bank_we_o), 0);
    chk("R11 done held", 32'(load_done_o), 1);

    // R2 reconfigure clears done and serial position
    configure(8'h02);
    chk("R2 done cleared", 32'(load_done_o), 0);
    data_i = 8'h80;
    wr_i = 1'b1;
    tick();
    wr_i = 1'b0;
    tick();
    chk("R2 R10 restart bit0", {bank_we_o, bank_bmask_o}, {6'h01, 24'h000001});

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule